// File: doc/BRIEF.md
# Interrupt summary and mask registers

This block gathers eleven level-sensitive interrupt request lines from two expansion slots, two on-board peripherals and a cascaded legacy interrupt controller. It presents them to software as two byte-wide registers at consecutive I/O addresses. Each input passes through a two-flop synchroniser. A per-line mask bit gates the input, and a single combined request goes to the processor whenever any enabled line is asserted.

A write to one of the two registers replaces the mask bits of the lines that register covers. A read returns the lines that are both asserted and enabled. Nothing is latched: a pending bit follows its input level. The default bit assignment is:

- Lower register, bits 0..7: slot 0 line A, slot 1 line A, slot 0 line B, slot 1 line B, slot 0 line C, the legacy controller cascade, the Ethernet device and the SCSI device.
- Upper register, bits 0..2: slot 1 line C, slot 0 line D and slot 1 line D.

At reset every line is masked, so no request reaches the processor until software clears mask bits.

Top module: `irq_summary_regs`

## Requirements
- R1: While reset is low and after it is released, every mask bit is 1. Before any write, `irq_o` is 0 and reads of both registers return 0, even with every input line high.
- R2: The register at offset 0 from `BASE_ADDR` covers lines 0..7, with bit n belonging to line n. A written 1 masks (disables) the line and a written 0 enables it.
- R3: The register at offset 1 covers lines 8..10 in bits 0..2, with bit n belonging to line 8+n.
- R4: Bits 3..7 of the register at offset 1 always read 0, and writes to them have no effect.
- R5: A read returns (synchronised input AND NOT mask) for the selected register. A bit stays 1 for as long as its input is held high, and returns to 0 when the input drops.
- R6: `irq_o` is the OR of all enabled, asserted lines. It reflects an input change at the third rising edge after the change, and a mask write at the first rising edge after the edge that performs the write.
- R7: `rdata_o` is loaded at the rising edge where `rd_i` is high and holds its value otherwise. A read at an address outside the two registers loads 0.
- R8: A write to an address outside the two registers changes no mask bit.
- R9: When a read and a write hit the same register in one cycle, the read returns data computed with the mask value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_lines_i | input | NUM_LINES (11) | Level-sensitive interrupt inputs, asynchronous |
| addr_i | input | ADDR_W (8) | I/O address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| irq_o | output | 1 | Combined interrupt request to the processor |

## Verification
An input change reaches the synchronised pending vector two edges later, and `irq_o` one edge after that. The bench therefore drives inputs on a falling edge and samples `irq_o` on the third falling edge that follows. A mask write takes effect at the edge that samples the strobe, and `irq_o` follows one edge later. The bench checks `irq_o` at both edges to confirm it is still unchanged at the first and updated at the second. Read data appears at the edge that samples `rd_i`, so every read is strobed for exactly one cycle and `rdata_o` is compared on the falling edge after that.

// File: rtl/irq_sum_pkg.sv
package irq_sum_pkg;
  localparam int BYTE_W = 8;

  function automatic int bytes_for(int lines);
    return (lines + BYTE_W - 1) / BYTE_W;
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 11,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
  import irq_sum_pkg::*;
#(
  parameter int NUM_LINES = 11,
  localparam int NUM_BYTES = bytes_for(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_BYTES-1:0] wr_byte_i,
  input  logic [BYTE_W-1:0]    wdata_i,
  output logic [NUM_LINES-1:0] mask_o
);
  // Only implemented lines own a flop; write bits past NUM_LINES are dropped.
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      bit_q <= 1'b1;
      else if (wr_byte_i[i / BYTE_W])   bit_q <= wdata_i[i % BYTE_W];
    end
    assign mask_o[i] = bit_q;
  end
endmodule

// File: rtl/irq_summary_view.sv
module irq_summary_view
  import irq_sum_pkg::*;
#(
  parameter int NUM_LINES = 11,
  localparam int NUM_BYTES = bytes_for(NUM_LINES),
  localparam int IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic [NUM_LINES-1:0] raw_i,
  input  logic [NUM_LINES-1:0] mask_i,
  input  logic                 hit_i,
  input  logic [IDX_W-1:0]     idx_i,
  output logic [BYTE_W-1:0]    byte_o,
  output logic                 any_o
);
  logic [NUM_LINES-1:0]        pend;
  logic [NUM_BYTES*BYTE_W-1:0] padded;

  always_comb begin
    pend   = raw_i & ~mask_i;
    padded = '0;
    padded[NUM_LINES-1:0] = pend;
    byte_o = hit_i ? padded[idx_i*BYTE_W +: BYTE_W] : '0;
    any_o  = |pend;
  end
endmodule

// File: rtl/irq_summary_regs.sv
module irq_summary_regs
  import irq_sum_pkg::*;
#(
  parameter int               NUM_LINES   = 11,
  parameter int               ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 8'h26,
  parameter int               SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_lines_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 rd_i,
  input  logic                 wr_i,
  input  logic [BYTE_W-1:0]    wdata_i,
  output logic [BYTE_W-1:0]    rdata_o,
  output logic                 irq_o
);
  localparam int NUM_BYTES = bytes_for(NUM_LINES);
  localparam int IDX_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

  logic [NUM_LINES-1:0] lines_sync;
  logic [NUM_LINES-1:0] line_mask;
  logic [NUM_BYTES-1:0] wr_byte;
  logic [ADDR_W-1:0]    offset;
  logic                 hit;
  logic [BYTE_W-1:0]    rd_byte;
  logic                 any_pend;
  logic [BYTE_W-1:0]    rdata_q;
  logic                 irq_q;

  assign offset = addr_i - BASE_ADDR;
  assign hit    = offset < ADDR_W'(NUM_BYTES);

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_wdec
    assign wr_byte[b] = wr_i && (addr_i == ADDR_W'(BASE_ADDR + b));
  end

  irq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (irq_lines_i),
    .q_o    (lines_sync)
  );

  irq_mask_bank #(.NUM_LINES(NUM_LINES)) u_mask (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_byte_i (wr_byte),
    .wdata_i   (wdata_i),
    .mask_o    (line_mask)
  );

  irq_summary_view #(.NUM_LINES(NUM_LINES)) u_view (
    .raw_i  (lines_sync),
    .mask_i (line_mask),
    .hit_i  (hit),
    .idx_i  (offset[IDX_W-1:0]),
    .byte_o (rd_byte),
    .any_o  (any_pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (rd_i) rdata_q <= rd_byte;
      irq_q <= any_pend;
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/irq_summary_chk.sv
module irq_summary_chk #(
  parameter int               NUM_LINES = 11,
  parameter int               ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h26
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [ADDR_W-1:0]    addr_i,
  input logic                 rd_i,
  input logic                 wr_i,
  input logic [7:0]           rdata_o,
  input logic                 irq_o,
  input logic [NUM_LINES-1:0] mask
);
  localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(BASE_ADDR + 1);

  // R4
  hi_rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == HI_ADDR) |=> (rdata_o[7:3] == 5'd0));

  // R7
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  // R7
  miss_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i != BASE_ADDR && addr_i != HI_ADDR) |=> (rdata_o == 8'd0));

  // R2
  lo_masked_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == BASE_ADDR && (&mask[7:0])) |=> (rdata_o == 8'd0));

  // R6
  all_masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask) |=> !irq_o);

  // R8
  mask_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(mask));
endmodule

bind irq_summary_regs irq_summary_chk #(
  .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .rd_i    (rd_i),
  .wr_i    (wr_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .mask    (line_mask)
);

// File: tb/irq_summary_regs_test.sv
`timescale 1ns/1ps
module irq_summary_regs_test;
  localparam int NL = 11;
  localparam logic [7:0] LO = 8'h26;
  localparam logic [7:0] HI = 8'h27;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NL-1:0] irq_lines_i = '0;
  logic [7:0]    addr_i = '0;
  logic          rd_i = 1'b0;
  logic          wr_i = 1'b0;
  logic [7:0]    wdata_i = '0;
  logic [7:0]    rdata_o;
  logic          irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk_i = ~clk_i;

  irq_summary_regs uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_lines_i(irq_lines_i),
    .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    d = rdata_o;
  endtask

  // Apply masks and inputs, wait out synchroniser and irq register, check all outputs.
  task automatic run_case(input string req, input logic [NL-1:0] lines,
                          input logic [7:0] mlo, input logic [7:0] mhi);
    logic [NL-1:0] pend;
    logic [7:0] d;
    wr_reg(LO, mlo);
    wr_reg(HI, mhi);
    irq_lines_i = lines;
    repeat (3) @(negedge clk_i);
    pend = lines & ~{mhi[2:0], mlo};
    chk({req, " irq"}, {7'd0, irq_o}, {7'd0, |pend});
    rd_reg(LO, d);
    chk({req, " lo"}, d, pend[7:0]);
    rd_reg(HI, d);
    chk({req, " hi"}, d, {5'd0, pend[10:8]});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    irq_lines_i = '1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    // R1 reset state with all inputs high
    chk("R1 irq after reset", {7'd0, irq_o}, 8'd0);
    rd_reg(LO, d); chk("R1 lo after reset", d, 8'd0);
    rd_reg(HI, d); chk("R1 hi after reset", d, 8'd0);

    // R2 single-line enables on the lower register
    for (int n = 0; n < 8; n++)
      run_case("R2 walk", '1, ~(8'd1 << n), 8'hFF);
    // R3 single-line enables on the upper register
    for (int n = 0; n < 3; n++)
      run_case("R3 walk", '1, 8'hFF, ~(8'd1 << n));

    // R5 sweep of masks against varied input patterns
    for (int i = 0; i < 256; i++)
      run_case("R5 sweep", NL'((i * 173) ^ 11'h5A5), 8'(i), 8'(~i));

    // R4 reserved upper bits
    run_case("R4 rsvd", '1, 8'h00, 8'h00);
    wr_reg(HI, 8'h00);
    rd_reg(HI, d); chk("R4 rsvd after zero write", d, 8'h07);

    // R5 level behaviour: bit clears when input drops
    wr_reg(LO, 8'h00);
    irq_lines_i = 11'h020;
    repeat (3) @(negedge clk_i);
    rd_reg(LO, d); chk("R5 level held", d, 8'h20);
    rd_reg(LO, d); chk("R5 level still held", d, 8'h20);
    irq_lines_i = '0;
    repeat (3) @(negedge clk_i);
    rd_reg(LO, d); chk("R5 level dropped", d, 8'h00);
    chk("R5 irq dropped", {7'd0, irq_o}, 8'd0);

    // R6 input latency: three edges
    wr_reg(LO, 8'h00); wr_reg(HI, 8'h00);
    @(negedge clk_i);
    irq_lines_i = 11'h400;
    repeat (2) @(negedge clk_i);
    chk("R6 irq not yet at edge 2", {7'd0, irq_o}, 8'd0);
    @(negedge clk_i);
    chk("R6 irq at edge 3", {7'd0, irq_o}, 8'd1);

    // R6 mask write latency: one edge after the write edge
    @(negedge clk_i);
    addr_i = HI; wdata_i = 8'hFF; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
    chk("R6 irq at write edge", {7'd0, irq_o}, 8'd1);
    @(negedge clk_i);
    chk("R6 irq after write", {7'd0, irq_o}, 8'd0);

    // R7 miss read returns 0, and rdata holds without strobe
    irq_lines_i = '1;
    wr_reg(LO, 8'h00);
    repeat (3) @(negedge clk_i);
    rd_reg(LO, d); chk("R7 lo read", d, 8'hFF);
    irq_lines_i = '0;
    repeat (4) @(negedge clk_i);
    chk("R7 hold without read", rdata_o, 8'hFF);
    rd_reg(8'h28, d); chk("R7 miss above", d, 8'h00);
    rd_reg(8'h25, d); chk("R7 miss below", d, 8'h00);

    // R8 writes elsewhere leave masks alone
    wr_reg(LO, 8'hFF); wr_reg(HI, 8'hFF);
    wr_reg(8'h28, 8'h00);
    wr_reg(8'h25, 8'h00);
    irq_lines_i = '1;
    repeat (3) @(negedge clk_i);
    chk("R8 irq after stray writes", {7'd0, irq_o}, 8'd0);
    rd_reg(LO, d); chk("R8 lo after stray writes", d, 8'h00);
    rd_reg(HI, d); chk("R8 hi after stray writes", d, 8'h00);

    // R9 read and write in the same cycle see the old mask
    @(negedge clk_i);
    addr_i = LO; wdata_i = 8'h0F; wr_i = 1'b1; rd_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0; rd_i = 1'b0;
    chk("R9 read during write", rdata_o, 8'h00);
    rd_reg(LO, d); chk("R9 read after write", d, 8'hF0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule